// File: doc/BRIEF.md
# Serial Converter Port (8-Channel, 12-Bit)

This block is the digital serial port of an eight-input, twelve-bit successive-approximation converter. A host drives an active-low select, a serial clock and a serial data line; the block returns each conversion as a sixteen-bit serial word on a data output with a separate output-enable. Select, serial clock and data input are treated as already synchronised to the system clock, and the block finds their edges by comparing each value with the one from the previous system cycle.

Every conversion takes sixteen serial clock periods. The block reports when the converter should be tracking its input and when it may power down. At the end of tracking it raises a one-cycle "sample now" strobe that carries the channel index. A converter model answers on a twelve-bit parallel code port, and the block shifts that code out after four leading zeros. The host chooses a channel during one conversion, and that choice applies to the conversion that follows. Select may stay low for several back-to-back conversions.

Top module: `serial_adc_port`

## Requirements
- R1: While `cs_n` is high, serial clock and data input edges have no effect: no strobe is produced and the stored channel is unchanged.
- R2: Falling serial clock edges are counted from 1 within a conversion. `track` is high after falling edges 1, 2 and 3 and low from falling edge 4 on.
- R3: The data output carries a zero after falling edges 1 to 4. After falling edges 5 to 16 it carries the twelve-bit code, most significant bit first, so a host that samples on rising edges reads `{4'b0, code}`.
- R4: `dout_oe` equals the inverse of `cs_n`, so the data output is enabled only inside a frame.
- R5: On rising edges 1 to 8 of a conversion, an eight-bit control word is shifted in from `din`, first bit received becoming bit 7. Bits 5..3 of the word are the channel for the next conversion. Bits 7, 6, 2, 1 and 0 are ignored.
- R6: After reset the stored channel is 0, so the first conversion samples channel 0.
- R7: If `cs_n` falls while the serial clock is low, that fall counts as falling edge 1. If `cs_n` falls while the serial clock is high, counting starts at the next serial clock fall.
- R8: While `cs_n` stays low, the falling edge that follows rising edge 16 starts a new conversion as falling edge 1.
- R9: `pwr_down` is high while `cs_n` is high. It is also high between falling edge 16 of a conversion and the next falling edge 1, and low at all other times in a frame.
- R10: `sample_req` pulses for one system cycle right after falling edge 4 of each conversion. `sample_chan` carries the channel stored before that conversion's control word was complete, and changes only with the pulse.
- R11: If `cs_n` rises before rising edge 8, the partial control word is discarded and the stored channel is kept. The next frame starts counting afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| din | input | 1 | Serial control word input |
| dout | output | 1 | Serial result output data |
| dout_oe | output | 1 | Output enable for `dout` (high drives, low is high impedance) |
| track | output | 1 | Converter should track its input |
| pwr_down | output | 1 | Converter may power down |
| sample_req | output | 1 | One-cycle sample strobe |
| sample_chan | output | 3 | Channel to sample with the strobe |
| sample_code | input | 12 | Code returned by the converter model |

## Verification
The bench builds the block with the package defaults: a twelve-bit result, a sixteen-clock conversion, a three-clock track window and an eight-bit control word with a three-bit channel field. With these values every channel code can be selected through the real control word. The don't-care bits can be set while the channel field is zero. A single frame can hold three back-to-back conversions, so the counter wrap and the gap between conversions are exercised alongside frames that open with the serial clock high or low and a frame aborted before its control word completes.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    localparam int RES_W     = 12;
    localparam int CONV_LEN  = 16;
    localparam int TRACK_LEN = 3;
    localparam int CTRL_W    = 8;
    localparam int CH_W      = 3;
    localparam int CH_LSB    = 3;
    localparam int LEAD_LEN  = CONV_LEN - RES_W;
    localparam int CNT_W     = $clog2(CONV_LEN + 1);

    typedef logic [CNT_W-1:0] edge_idx_t;
    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [RES_W-1:0] code_t;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_WAIT,
        PH_TRACK,
        PH_HOLD,
        PH_GAP
    } phase_e;

    // next-state view of the edge counters handed to the datapath
    typedef struct packed {
        logic      fall_step;
        logic      rise_step;
        edge_idx_t fall_idx;
        edge_idx_t rise_idx;
    } step_t;

    function automatic phase_e phase_of(input logic active, input edge_idx_t fidx);
        if (!active)
            return PH_OFF;
        else if (fidx == '0)
            return PH_WAIT;
        else if (fidx <= edge_idx_t'(TRACK_LEN))
            return PH_TRACK;
        else if (fidx == edge_idx_t'(CONV_LEN))
            return PH_GAP;
        else
            return PH_HOLD;
    endfunction

endpackage

// File: rtl/aport_edge_sense.sv
module aport_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    output logic active,
    output logic frame_open,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    assign active     = ~cs_n;
    assign frame_open = cs_q & ~cs_n;
    assign sclk_rise  = active & ~sclk_q & sclk;
    assign sclk_fall  = active & sclk_q & ~sclk;
endmodule

// File: rtl/aport_sequencer.sv
module aport_sequencer
    import adc_port_pkg::*;
#(
    parameter int LEN = CONV_LEN
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   frame_open,
    input  logic   sclk,
    input  logic   sclk_rise,
    input  logic   sclk_fall,
    output step_t  step,
    output phase_e phase
);
    localparam edge_idx_t LAST = edge_idx_t'(LEN);
    localparam edge_idx_t ONE  = edge_idx_t'(1);

    edge_idx_t fall_idx;
    edge_idx_t rise_idx;

    always_comb begin
        step.fall_step = 1'b0;
        step.rise_step = 1'b0;
        step.fall_idx  = fall_idx;
        step.rise_idx  = rise_idx;
        if (!active) begin
            step.fall_idx = '0;
            step.rise_idx = '0;
        end else if (frame_open) begin
            step.rise_idx = '0;
            if (!sclk) begin
                step.fall_idx  = ONE;
                step.fall_step = 1'b1;
            end else begin
                step.fall_idx = '0;
            end
        end else if (sclk_fall) begin
            step.fall_step = 1'b1;
            if (fall_idx == LAST) begin
                step.fall_idx = ONE;
                step.rise_idx = '0;
            end else begin
                step.fall_idx = fall_idx + ONE;
            end
        end else if (sclk_rise && rise_idx != LAST) begin
            step.rise_step = 1'b1;
            step.rise_idx  = rise_idx + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_idx <= '0;
            rise_idx <= '0;
        end else begin
            fall_idx <= step.fall_idx;
            rise_idx <= step.rise_idx;
        end
    end

    assign phase = phase_of(active, fall_idx);
endmodule

// File: rtl/aport_ctrl_capture.sv
module aport_ctrl_capture
    import adc_port_pkg::*;
#(
    parameter int WORD_W = CTRL_W,
    parameter int FLD_W  = CH_W,
    parameter int FLD_LO = CH_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_step,
    input  edge_idx_t        rise_idx,
    input  logic             din,
    output logic [FLD_W-1:0] chan
);
    localparam edge_idx_t WORD_END = edge_idx_t'(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word;

    assign word = {shreg[WORD_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            chan  <= '0;
        end else if (rise_step && rise_idx <= WORD_END) begin
            shreg <= word;
            if (rise_idx == WORD_END)
                chan <= word[FLD_LO +: FLD_W];
        end
    end
endmodule

// File: rtl/aport_result_shift.sv
module aport_result_shift
    import adc_port_pkg::*;
#(
    parameter int W     = RES_W,
    parameter int LEN   = CONV_LEN,
    parameter int TRACK = TRACK_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         fall_step,
    input  edge_idx_t    fall_idx,
    input  chan_t        chan_cur,
    input  logic [W-1:0] code,
    output logic         dout_bit,
    output logic         sample_req,
    output chan_t        sample_chan
);
    localparam edge_idx_t HOLD_IDX = edge_idx_t'(TRACK + 1);
    localparam edge_idx_t LOAD_IDX = edge_idx_t'(LEN - W + 1);

    logic [W-1:0] shreg;
    logic         hold_edge;

    assign hold_edge = fall_step && fall_idx == HOLD_IDX;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            dout_bit   <= 1'b0;
            shreg      <= '0;
            sample_req <= 1'b0;
        end else begin
            sample_req <= hold_edge;
            if (fall_step) begin
                if (fall_idx == LOAD_IDX) begin
                    dout_bit <= code[W-1];
                    shreg    <= {code[W-2:0], 1'b0};
                end else if (fall_idx > LOAD_IDX) begin
                    dout_bit <= shreg[W-1];
                    shreg    <= {shreg[W-2:0], 1'b0};
                end else begin
                    dout_bit <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sample_chan <= '0;
        else if (active && hold_edge)
            sample_chan <= chan_cur;
    end
endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port
    import adc_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        din,
    output logic        dout,
    output logic        dout_oe,
    output logic        track,
    output logic        pwr_down,
    output logic        sample_req,
    output logic [2:0]  sample_chan,
    input  logic [11:0] sample_code
);
    logic   active;
    logic   frame_open;
    logic   sclk_rise;
    logic   sclk_fall;
    step_t  step;
    phase_e phase;
    chan_t  chan_cur;

    aport_edge_sense u_edges (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .active     (active),
        .frame_open (frame_open),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall)
    );

    aport_sequencer #(.LEN(CONV_LEN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .frame_open (frame_open),
        .sclk       (sclk),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .step       (step),
        .phase      (phase)
    );

    aport_ctrl_capture #(.WORD_W(CTRL_W), .FLD_W(CH_W), .FLD_LO(CH_LSB)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rise_step (step.rise_step),
        .rise_idx  (step.rise_idx),
        .din       (din),
        .chan      (chan_cur)
    );

    aport_result_shift #(.W(RES_W), .LEN(CONV_LEN), .TRACK(TRACK_LEN)) u_res (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .fall_step   (step.fall_step),
        .fall_idx    (step.fall_idx),
        .chan_cur    (chan_cur),
        .code        (sample_code),
        .dout_bit    (dout),
        .sample_req  (sample_req),
        .sample_chan (sample_chan)
    );

    assign dout_oe  = active;
    assign track    = (phase == PH_TRACK);
    assign pwr_down = (phase == PH_OFF) || (phase == PH_GAP);
endmodule

// File: rtl/serial_adc_port_chk.sv
module serial_adc_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       dout,
    input logic       dout_oe,
    input logic       track,
    input logic       pwr_down,
    input logic       sample_req,
    input logic [2:0] sample_chan
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!track && pwr_down && !dout_oe)); // R1

    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> dout_oe); // R4

    AST_TRACK_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        track |-> !dout); // R3

    AST_PD_NOT_TRACK: assert property (@(posedge clk) disable iff (rst)
        !(track && pwr_down)); // R9

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_req |=> !sample_req); // R10

    AST_STROBE_ENDS_TRACK: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> ($past(track) && !track)); // R2

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
        !sample_req |-> $stable(sample_chan)); // R10
endmodule

bind serial_adc_port serial_adc_port_chk chk (.*);

// File: tb/serial_adc_port_test.sv
module serial_adc_port_test;
    import adc_port_pkg::*;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n;
    logic        sclk;
    logic        din;
    logic        dout;
    logic        dout_oe;
    logic        track;
    logic        pwr_down;
    logic        sample_req;
    logic [2:0]  sample_chan;
    logic [11:0] sample_code = '0;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [2:0]  model_chan = '0;
    logic [2:0]  chan_q[$];
    logic [15:0] word_q[$];
    logic [15:0] rx_bits = '0;
    int          rx_cnt = 0;

    always #4 clk = ~clk;

    serial_adc_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .track(track), .pwr_down(pwr_down),
        .sample_req(sample_req), .sample_chan(sample_chan), .sample_code(sample_code)
    );

    function automatic logic [11:0] code_for(input logic [2:0] c);
        return 12'h5A3 ^ {c, c, c, c};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter stand-in: answer the strobe with a channel-dependent code
    always @(posedge clk)
        if (sample_req) sample_code <= code_for(sample_chan);

    // monitor: strobes against the expected channel queue
    always @(negedge clk) begin
        if (sample_req) begin
            if (chan_q.size() == 0)
                check("R10 unexpected strobe", 1, 0);
            else
                check("R10/R5 strobe channel", sample_chan, chan_q.pop_front());
        end
    end

    // monitor: host-side word capture on rising serial clock edges
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            rx_cnt = 0;
        end else begin
            rx_bits = {rx_bits[14:0], dout};
            rx_cnt++;
            if (rx_cnt == CONV_LEN) begin
                rx_cnt = 0;
                if (word_q.size() == 0)
                    check("R3 unexpected word", 1, 0);
                else
                    check("R3 serial word", rx_bits, word_q.pop_front());
            end
        end
    end

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic half(input logic v);
        sclk = v;
        wait_half();
    endtask

    task automatic open_frame(input bit sclk_high);
        if (sclk_high) begin
            half(1'b1);
            cs_n = 1'b0;
            wait_half();
            check("R7 no track before first fall", track, 0);
            half(1'b0);
        end else begin
            half(1'b0);
            cs_n = 1'b0;
            wait_half();
        end
        check("R7 track after first fall", track, 1);
    endtask

    task automatic close_frame();
        cs_n = 1'b1;
        wait_half();
        check("R4 output disabled", dout_oe, 0);
        check("R9 powered down idle", pwr_down, 1);
        check("R1 no track idle", track, 0);
    endtask

    // one conversion: nrise rising edges, ctrl shifted on the first eight
    task automatic convert(input logic [7:0] ctrl, input int nrise, input bit more);
        if (nrise == CONV_LEN)
            word_q.push_back({4'b0000, code_for(model_chan)});
        for (int k = 1; k <= nrise; k++) begin
            check($sformatf("R2 track after fall %0d", k), track, (k <= TRACK_LEN) ? 1 : 0);
            check($sformatf("R9 power-down after fall %0d", k), pwr_down, (k == CONV_LEN) ? 1 : 0);
            if (k == 1) check("R4 output enabled", dout_oe, 1);
            if (k == TRACK_LEN) chan_q.push_back(model_chan);
            din = (k <= CTRL_W) ? ctrl[CTRL_W - k] : 1'b0;
            half(1'b1);
            if (k == CTRL_W) model_chan = ctrl[5:3];
            if (k < CONV_LEN || more) half(1'b0);
        end
    endtask

    task automatic idle_clocks(input logic [7:0] pattern);
        for (int k = 0; k < CTRL_W; k++) begin
            din = pattern[7 - k];
            half(1'b1);
            half(1'b0);
            check("R1 no strobe with select high", sample_req, 0);
        end
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4 reset output enable", dout_oe, 0);
        check("R9 reset power-down", pwr_down, 1);
        check("R2 reset track", track, 0);
        check("R10 reset strobe", sample_req, 0);

        // clocks with select high carry a channel-6 word: must be ignored
        idle_clocks(8'b0011_0000);

        // R6: first conversion after reset samples channel 0; asks for 5
        open_frame(0);
        convert(8'b0010_1000, CONV_LEN, 0);
        close_frame();

        // R7 select falls with clock high; R5 don't-care bits set, field 000
        open_frame(1);
        convert(8'b1100_0111, CONV_LEN, 0);
        close_frame();

        // R8 three back-to-back conversions in one frame
        open_frame(0);
        convert(8'b0001_1000, CONV_LEN, 1);
        convert(8'b0011_1000, CONV_LEN, 1);
        convert(8'b0001_0000, CONV_LEN, 0);
        close_frame();

        // R1 ignored clocks again, then R11 abort before the word completes
        idle_clocks(8'b0011_1111);
        open_frame(0);
        convert(8'b0010_0000, 6, 0);
        close_frame();

        // R11 channel 2 kept, counting restarts cleanly
        open_frame(1);
        convert(8'b0000_1000, CONV_LEN, 0);
        close_frame();

        open_frame(0);
        convert(8'b0000_0000, CONV_LEN, 0);
        close_frame();

        repeat (4) @(negedge clk);
        check("R10 all strobes seen", chan_q.size(), 0);
        check("R3 all words seen", word_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule